// File: doc/BRIEF.md
# Halt-Mode Clock Shutdown and Wake Sequencer

This block steps a processor's clock tree down into a deep halt state and brings it back up in a fixed order. When the core asks to idle, the sequencer keeps every clock running for a drain window, so that the pipeline and any pending work can finish. It then gates the core and peripheral clocks and powers down the PLL. The oscillator enable is also dropped, but only when the clock comes from a crystal or resonator.

Wake-up has two phases. The wake pin going low turns the oscillator back on. The wake pin returning high, after it has stayed low long enough, starts a fixed PLL lock count. When the lock count ends, the core and peripheral clocks come back on. A resume latency then runs, and its length depends on whether the code resumes from on-chip RAM or from flash. A one-cycle strobe marks the return to normal execution. The oscillator itself is represented only by its enable. The wake pin is sampled through a synchronizer into the reference clock domain.

Top module: `halt_seq_ctrl`

## Requirements
- R1: After reset, core_clk_en, periph_clk_en, pll_en and osc_en are all 1, and halted and resume_pulse are 0.
- R2: An idle_req sampled high while running keeps core_clk_en and periph_clk_en at 1 for exactly DRAIN_CYC cycles, counting the accepting edge. After that, both clock enables and pll_en are 0 and halted is 1.
- R3: While halted and waiting for a wake, osc_en equals the inverse of xtal_src, where xtal_src=1 means a crystal or resonator source.
- R4: A low level on wake_n, seen after the synchronizer (SYNC_STAGES cycles), sets osc_en to 1 while pll_en stays 0.
- R5: A low pulse on wake_n shorter than OSC_START_CYC+2 cycles is rejected. The block returns to waiting in halt with osc_en as in R3, and no PLL lock starts.
- R6: When wake_n rises after a low pulse of at least OSC_START_CYC+2 cycles, pll_en goes to 1 while core_clk_en stays 0, for exactly LOCK_CYC cycles.
- R7: After the lock count, core_clk_en and periph_clk_en are 1 and halted stays 1 for RES_RAM_CYC cycles when boot_flash=0, or RES_FLASH_CYC cycles when boot_flash=1. boot_flash is sampled when the lock count ends.
- R8: resume_pulse is high for exactly one cycle, which is the last resume-latency cycle. In the next cycle halted is 0.
- R9: An idle_req that arrives while halted, draining or waking has no effect on the sequence, and it is not remembered after the return to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator reference clock; all sequencing is counted in this clock |
| rst_n | input | 1 | Asynchronous active-low reset; returns the block to running |
| idle_req | input | 1 | Request to enter halt, accepted only while running |
| wake_n | input | 1 | Active-low wake pin, asynchronous to clk |
| boot_flash | input | 1 | 1 selects the flash resume latency, 0 selects the RAM resume latency |
| xtal_src | input | 1 | 1 when a crystal or resonator drives the oscillator |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| pll_en | output | 1 | PLL power enable |
| osc_en | output | 1 | Oscillator enable |
| halted | output | 1 | High from the end of the drain window until execution resumes |
| resume_pulse | output | 1 | One-cycle strobe marking the return to execution |

## Verification
The bench sweeps the wake pulse width from one cycle up to a few cycles past the acceptance threshold. This shows that noise rejection switches exactly at OSC_START_CYC+2 and that no lock starts below that width. Every width runs under both oscillator-source settings, which checks the halt-time oscillator enable, and under both resume sources, which checks that the two latencies are applied separately. One pass holds idle_req high through drain, halt and wake, to show that a request outside the running state neither shortens any window nor triggers a new halt afterwards.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_DRAIN  = 3'd1,
    ST_HALT   = 3'd2,
    ST_OSCUP  = 3'd3,
    ST_LOCK   = 3'd4,
    ST_RESUME = 3'd5
  } seq_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/halt_wake_sync.sv
module halt_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/halt_span_cnt.sv
module halt_span_cnt #(
  parameter int MAXV = 1024,
  localparam int W = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = W'(MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count <= '0;
    else if (clr)         count <= '0;
    else if (count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/halt_seq_ctrl.sv
module halt_seq_ctrl
  import halt_seq_pkg::*;
#(
  parameter int DRAIN_CYC     = 32,
  parameter int LOCK_CYC      = 131072,
  parameter int OSC_START_CYC = 16,
  parameter int RES_RAM_CYC   = 35,
  parameter int RES_FLASH_CYC = 1125,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_req,
  input  logic wake_n,
  input  logic boot_flash,
  input  logic xtal_src,
  output logic core_clk_en,
  output logic periph_clk_en,
  output logic pll_en,
  output logic osc_en,
  output logic halted,
  output logic resume_pulse
);
  localparam int MIN_LOW = OSC_START_CYC + 2;
  localparam int CNT_MAX = max_of(max_of(DRAIN_CYC, LOCK_CYC),
                                  max_of(max_of(RES_RAM_CYC, RES_FLASH_CYC), MIN_LOW));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(DRAIN_CYC - 1);
  localparam logic [CNT_W-1:0] LOCK_LAST  = CNT_W'(LOCK_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_OK     = CNT_W'(MIN_LOW - 1);
  localparam logic [CNT_W-1:0] RAM_LAST   = CNT_W'(RES_RAM_CYC - 1);
  localparam logic [CNT_W-1:0] FLASH_LAST = CNT_W'(RES_FLASH_CYC - 1);

  seq_state_t       state, state_nx;
  logic [CNT_W-1:0] span;
  logic             wake_s;
  logic             flash_sel;
  logic             res_last;

  halt_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (wake_n),
    .pin_sync  (wake_s)
  );

  halt_span_cnt #(.MAXV(CNT_MAX)) u_span (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_nx != state),
    .count (span)
  );

  assign res_last = (state == ST_RESUME) &&
                    (span == (flash_sel ? FLASH_LAST : RAM_LAST));

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:    if (idle_req) state_nx = ST_DRAIN;
      ST_DRAIN:  if (span == DRAIN_LAST) state_nx = ST_HALT;
      ST_HALT:   if (!wake_s) state_nx = ST_OSCUP;
      ST_OSCUP:  if (wake_s) state_nx = (span >= LOW_OK) ? ST_LOCK : ST_HALT;
      ST_LOCK:   if (span == LOCK_LAST) state_nx = ST_RESUME;
      ST_RESUME: if (res_last) state_nx = ST_RUN;
      default:   state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      flash_sel <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_LOCK && state_nx == ST_RESUME) flash_sel <= boot_flash;
    end
  end

  always_comb begin
    core_clk_en   = 1'b1;
    periph_clk_en = 1'b1;
    pll_en        = 1'b1;
    osc_en        = 1'b1;
    halted        = 1'b0;
    unique case (state)
      ST_RUN, ST_DRAIN: ;
      ST_HALT: begin
        core_clk_en   = 1'b0;
        periph_clk_en = 1'b0;
        pll_en        = 1'b0;
        osc_en        = !xtal_src;
        halted        = 1'b1;
      end
      ST_OSCUP: begin
        core_clk_en   = 1'b0;
        periph_clk_en = 1'b0;
        pll_en        = 1'b0;
        halted        = 1'b1;
      end
      ST_LOCK: begin
        core_clk_en   = 1'b0;
        periph_clk_en = 1'b0;
        halted        = 1'b1;
      end
      ST_RESUME: halted = 1'b1;
      default: ;
    endcase
  end

  assign resume_pulse = res_last;
endmodule

// File: rtl/halt_seq_chk.sv
module halt_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic core_clk_en,
  input logic periph_clk_en,
  input logic pll_en,
  input logic osc_en,
  input logic halted,
  input logic resume_pulse
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse); // R8
  AST_STROBE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !halted); // R8
  AST_HALT_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> (!core_clk_en && !periph_clk_en && !pll_en)); // R2
  AST_PLL_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |-> osc_en); // R4
  AST_CORE_WAITS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !pll_en) |-> !core_clk_en); // R6
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !resume_pulse) |=> halted); // R9
endmodule

bind halt_seq_ctrl halt_seq_chk u_halt_seq_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_clk_en   (core_clk_en),
  .periph_clk_en (periph_clk_en),
  .pll_en        (pll_en),
  .osc_en        (osc_en),
  .halted        (halted),
  .resume_pulse  (resume_pulse)
);

// File: tb/tb_halt_seq_ctrl.sv
module tb_halt_seq_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DRAIN = 4;
  localparam int LOCK  = 64;
  localparam int OSCST = 6;
  localparam int RRAM  = 5;
  localparam int RFL   = 11;
  localparam int MINLOW = OSCST + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_req = 1'b0;
  logic wake_n = 1'b1;
  logic boot_flash = 1'b0;
  logic xtal_src = 1'b0;
  logic core_clk_en, periph_clk_en, pll_en, osc_en, halted, resume_pulse;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  halt_seq_ctrl #(
    .DRAIN_CYC(DRAIN), .LOCK_CYC(LOCK), .OSC_START_CYC(OSCST),
    .RES_RAM_CYC(RRAM), .RES_FLASH_CYC(RFL), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .wake_n(wake_n),
    .boot_flash(boot_flash), .xtal_src(xtal_src),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .pll_en(pll_en), .osc_en(osc_en), .halted(halted), .resume_pulse(resume_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input bit xs, input bit bf, input int w, input bit hold_idle);
    int dc, lockc, resc, strobes, strobe_at, lat;
    bit accept;
    accept = (w >= MINLOW);
    lat = bf ? RFL : RRAM;
    @(negedge clk);
    rst_n = 1'b0; idle_req = 1'b0; wake_n = 1'b1;
    xtal_src = xs; boot_flash = bf;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 enables", {core_clk_en, periph_clk_en, pll_en, osc_en}, 4'b1111);
    chk("R1 flags", {halted, resume_pulse}, 0);
    idle_req = 1'b1;
    @(negedge clk);
    idle_req = hold_idle;
    dc = 0;
    while (core_clk_en && dc < 100) begin
      dc++;
      @(negedge clk);
    end
    chk("R2 drain length", dc, DRAIN);
    chk("R2 halt state", {periph_clk_en, pll_en, halted}, 3'b001);
    chk("R3 osc in halt", osc_en, !xs);
    wake_n = 1'b0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (i == 2 && w >= 3) chk("R4 osc on, pll off", {osc_en, pll_en}, 2'b10);
    end
    wake_n = 1'b1;
    lockc = 0; resc = 0; strobes = 0; strobe_at = 0;
    for (int k = 0; k < LOCK + RFL + 40; k++) begin
      @(negedge clk);
      if (!halted) break;
      if (pll_en && !core_clk_en) lockc++;
      if (core_clk_en) begin
        resc++;
        idle_req = 1'b0;
      end
      if (resume_pulse) begin
        strobes++;
        strobe_at = resc;
      end
    end
    if (accept) begin
      chk("R6 lock length", lockc, LOCK);
      chk("R7 resume latency", resc, lat);
      chk("R8 single strobe", strobes, 1);
      chk("R8 strobe in last cycle", strobe_at, lat);
      chk("R8 halted cleared", halted, 0);
      dc = 0;
      for (int k = 0; k < DRAIN + 3; k++) begin
        if (core_clk_en && periph_clk_en && !halted) dc++;
        @(negedge clk);
      end
      chk(hold_idle ? "R9 stale idle ignored" : "R7 stays running", dc, DRAIN + 3);
    end else begin
      chk("R5 no lock", lockc, 0);
      chk("R5 still halted", {halted, strobes[0]}, 2'b10);
      chk("R5 osc back to halt value", osc_en, !xs);
    end
    idle_req = 1'b0;
  endtask

  initial begin
    for (int xs = 0; xs < 2; xs++)
      for (int bf = 0; bf < 2; bf++)
        for (int w = 1; w <= MINLOW + 2; w++)
          run_case(xs[0], bf[0], w, 1'b0);
    run_case(1'b1, 1'b0, MINLOW + 2, 1'b1);
    run_case(1'b0, 1'b1, MINLOW, 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule